// File: doc/BRIEF.md
# Array Range Finder

This block walks a read-only memory of unsigned words that is already loaded and reports the spread of its contents. The spread is the largest value in the memory minus the smallest. A finite-state controller sequences a small datapath. The datapath holds an index counter one bit wider than the memory address, a running-maximum register, a running-minimum register and a result register. The low bits of the index form the read address. The memory is read combinationally, so the word at the current address can be compared in the same cycle.

The controller's state register changes on the falling clock edge, and every datapath register changes on the rising edge. Each control signal therefore has half a cycle to settle before the datapath acts on it. While the controller is idle it keeps the index at zero, forces the running maximum to zero through a synchronous clear and forces the running minimum to all ones through a synchronous set. A start pulse then begins the scan. For every entry the controller spends four states: end-of-array test, maximum update, minimum update and index step. When the index reaches the memory depth, the controller latches the spread into the result register, raises done for one cycle and returns to idle. The result stays on its output until the next scan completes.

Top module: `rng_finder`

## Requirements
- R1: While `rst` is high at a rising edge, the block returns to idle: `done` is 0, `diff` is 0 and `rd_addr` is 0.
- R2: After a scan, `diff` equals the largest minus the smallest of all 2^ADDR_W entries, each read as an unsigned DATA_W-bit number.
- R3: When every entry holds the same value, `diff` is 0.
- R4: Entries at address 0 and at the last address take part in the result. With the minimum at one end and the maximum at the other, `diff` equals their difference, including the full range 255 for 8-bit data.
- R5: `done` is high at exactly one rising edge per scan. `diff` takes its new value at that edge and holds it until the next scan completes.
- R6: During a scan, `rd_addr` starts at 0 and steps up by one, covering every address once in increasing order. After the last address it returns to 0, for 2^ADDR_W steps in total per scan.
- R7: `start` is only acted on in idle. A pulse during a scan changes neither the result nor the timing. After a scan, `rd_addr` rests at 0 and a new start scans again from address 0.
- R8: Let E be the first rising edge after the falling edge at which idle sees `start` high. `done` is high at the rising edge 4*2^ADDR_W + 1 edges after E.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; controller on falling edge, datapath on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a scan; sampled by the controller in idle |
| rd_addr | output | ADDR_W | Memory read address, the low bits of the index |
| rd_data | input | DATA_W | Word at `rd_addr`, valid combinationally |
| done | output | 1 | High for one cycle when the result is latched |
| diff | output | DATA_W | Largest minus smallest entry of the last scan |

## Verification
The bench builds the block with its default parameters: 8-bit data and an 8-bit address, giving a 256-entry array and a 9-bit index. With these values the index reaches 256 exactly when the address field wraps to 0. The extremes 0 and 255 of the data range can therefore be placed at the first and last address in one run. At about a thousand cycles per scan, the bench can run several random arrays, arrays of equal values, back-to-back restarts and a start pulse in the middle of a scan, and check the exact latency of each.

// File: rtl/rng_pkg.sv
package rng_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_TEST = 3'd1,
      ST_HI   = 3'd2,
      ST_LO   = 3'd3,
      ST_STEP = 3'd4,
      ST_FIN  = 3'd5
   } rng_state_e;

endpackage

// File: rtl/rng_ctrl.sv
module rng_ctrl
   import rng_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic idx_end,
   input  logic above_max,
   input  logic below_min,
   output logic idx_en,
   output logic idx_clr,
   output logic idx_inc,
   output logic max_clr,
   output logic min_set,
   output logic max_ld,
   output logic min_ld,
   output logic diff_ld,
   output logic done
);

   rng_state_e state, nxt;

   // state register on the falling edge; datapath acts on the next rising edge
   always_ff @(negedge clk) begin
      if (rst) state <= ST_IDLE;
      else     state <= nxt;
   end

   always_comb begin
      nxt     = state;
      idx_en  = 1'b0;
      idx_clr = 1'b0;
      idx_inc = 1'b0;
      max_clr = 1'b0;
      min_set = 1'b0;
      max_ld  = 1'b0;
      min_ld  = 1'b0;
      diff_ld = 1'b0;
      done    = 1'b0;
      case (state)
         ST_IDLE: begin
            idx_en  = 1'b1;
            idx_clr = 1'b1;
            max_clr = 1'b1;
            min_set = 1'b1;
            if (start) nxt = ST_TEST;
         end
         ST_TEST: nxt = idx_end ? ST_FIN : ST_HI;
         ST_HI: begin
            max_ld = above_max;
            nxt    = ST_LO;
         end
         ST_LO: begin
            min_ld = below_min;
            nxt    = ST_STEP;
         end
         ST_STEP: begin
            idx_en  = 1'b1;
            idx_inc = 1'b1;
            nxt     = ST_TEST;
         end
         ST_FIN: begin
            done    = 1'b1;
            diff_ld = 1'b1;
            nxt     = ST_IDLE;
         end
         default: nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/rng_idx_counter.sv
module rng_idx_counter #(
   parameter int IDX_W = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             clr,
   input  logic             inc,
   output logic [IDX_W-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst)           q <= '0;
      else if (en) begin
         if (clr)        q <= '0;
         else if (inc)   q <= q + IDX_W'(1);
      end
   end

endmodule

// File: rtl/rng_extreme.sv
module rng_extreme #(
   parameter int W        = 8,
   parameter bit KEEP_MAX = 1'b1
) (
   input  logic         clk,
   input  logic         sync_clr,
   input  logic         sync_set,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         wins
);

   generate
      if (KEEP_MAX) begin : g_hi
         assign wins = (d > q);
      end else begin : g_lo
         assign wins = (d < q);
      end
   endgenerate

   // initial value comes only from the dedicated clear / set inputs
   always_ff @(posedge clk) begin
      if (sync_clr)      q <= '0;
      else if (sync_set) q <= '1;
      else if (ld)       q <= d;
   end

endmodule

// File: rtl/rng_finder.sv
module rng_finder #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              done,
   output logic [DATA_W-1:0] diff
);

   localparam int IDX_W = ADDR_W + 1;

   generate
      if (DATA_W < 2) begin : g_bad_data_w
         $error("rng_finder: DATA_W must be at least 2");
      end
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr_w
         $error("rng_finder: ADDR_W must lie in 1..16");
      end
   endgenerate

   logic             ctl_idx_en, ctl_idx_clr, ctl_idx_inc;
   logic             ctl_max_clr, ctl_min_set, ctl_max_ld, ctl_min_ld, ctl_diff_ld;
   logic             above_max, below_min;
   logic [IDX_W-1:0] idx_q;
   logic [DATA_W-1:0] max_q, min_q;

   rng_ctrl u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .idx_end   (idx_q[ADDR_W]),
      .above_max (above_max),
      .below_min (below_min),
      .idx_en    (ctl_idx_en),
      .idx_clr   (ctl_idx_clr),
      .idx_inc   (ctl_idx_inc),
      .max_clr   (ctl_max_clr),
      .min_set   (ctl_min_set),
      .max_ld    (ctl_max_ld),
      .min_ld    (ctl_min_ld),
      .diff_ld   (ctl_diff_ld),
      .done      (done)
   );

   rng_idx_counter #(.IDX_W(IDX_W)) u_idx (
      .clk (clk),
      .rst (rst),
      .en  (ctl_idx_en),
      .clr (ctl_idx_clr),
      .inc (ctl_idx_inc),
      .q   (idx_q)
   );

   rng_extreme #(.W(DATA_W), .KEEP_MAX(1'b1)) u_max (
      .clk      (clk),
      .sync_clr (rst | ctl_max_clr),
      .sync_set (1'b0),
      .ld       (ctl_max_ld),
      .d        (rd_data),
      .q        (max_q),
      .wins     (above_max)
   );

   rng_extreme #(.W(DATA_W), .KEEP_MAX(1'b0)) u_min (
      .clk      (clk),
      .sync_clr (1'b0),
      .sync_set (rst | ctl_min_set),
      .ld       (ctl_min_ld),
      .d        (rd_data),
      .q        (min_q),
      .wins     (below_min)
   );

   assign rd_addr = idx_q[ADDR_W-1:0];

   always_ff @(posedge clk) begin
      if (rst)              diff <= '0;
      else if (ctl_diff_ld) diff <= max_q - min_q;
   end

endmodule

// File: rtl/rng_finder_chk.sv
module rng_finder_chk #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              done,
   input logic [DATA_W-1:0] diff,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] max_q,
   input logic [DATA_W-1:0] min_q,
   input logic              max_clr
);

   localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R5
   diff_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(diff) |-> $past(done));

   // R2
   diff_value_chk: assert property (@(posedge clk) disable iff (rst)
      $past(done) |-> (diff == ($past(max_q) - $past(min_q))));

   // R2
   max_monotone_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(max_clr) |-> (max_q >= $past(max_q)));

   // R6
   addr_step_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(rd_addr) |-> (rd_addr == ($past(rd_addr) + ADDR_ONE)));

endmodule

bind rng_finder rng_finder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rng_chk (
   .clk     (clk),
   .rst     (rst),
   .done    (done),
   .diff    (diff),
   .rd_addr (rd_addr),
   .max_q   (max_q),
   .min_q   (min_q),
   .max_clr (ctl_max_clr)
);

// File: tb/rng_finder_bench.sv
module rng_finder_bench;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 8;
   localparam int AW         = 8;
   localparam int DEPTH      = 1 << AW;
   localparam int LATENCY    = 4 * DEPTH + 1;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          start = 1'b0;
   logic [AW-1:0] rd_addr;
   logic [DW-1:0] rd_data;
   logic          done;
   logic [DW-1:0] diff;

   logic [DW-1:0] mem [DEPTH];
   assign rd_data = mem[rd_addr];

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   int start_cyc = 0;
   int addr_changes = 0;
   int addr_bad = 0;
   int exp_q[$];
   string tag_q[$];

   rng_finder #(.DATA_W(DW), .ADDR_W(AW)) u_rng_finder (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .done    (done),
      .diff    (diff)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // monitor: pops expected results as done appears
   initial begin
      logic [AW-1:0] prev_addr;
      bit            prev_done;
      prev_addr = '0;
      prev_done = 1'b0;
      forever begin
         @(posedge clk);
         #1;
         if (rst) begin
            prev_addr = rd_addr;
            prev_done = 1'b0;
         end else begin
            if (rd_addr != prev_addr) begin
               addr_changes++;
               if (rd_addr != AW'(prev_addr + 1)) addr_bad++;
            end
            prev_addr = rd_addr;
            if (done && prev_done) check(1'b0, "R5", "done high two cycles", 1, 0);
            if (done) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5", "done without a scan", 1, 0);
               end else begin
                  int    e;
                  string t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  check(int'(diff) == e, t, "diff", int'(diff), e);
                  check(cyc - start_cyc == LATENCY, "R8", "latency",
                        cyc - start_cyc, LATENCY);
                  check(addr_changes == DEPTH && addr_bad == 0, "R6",
                        "address steps", addr_changes - addr_bad, DEPTH);
               end
            end
            prev_done = done;
         end
      end
   end

   // driver: pushes the expected result, pulses start, waits for the monitor
   task automatic scan(input string req, input bit poke);
      int mx, mn, e, waited;
      mx = 0;
      mn = (1 << DW) - 1;
      for (int i = 0; i < DEPTH; i++) begin
         if (int'(mem[i]) > mx) mx = int'(mem[i]);
         if (int'(mem[i]) < mn) mn = int'(mem[i]);
      end
      e = mx - mn;
      exp_q.push_back(e);
      tag_q.push_back(req);
      @(posedge clk); #1;
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      start_cyc = cyc;
      addr_changes = 0;
      addr_bad = 0;
      if (poke) begin
         // R7: a start pulse mid-scan must be ignored
         repeat (300) @(posedge clk);
         #1 start = 1'b1;
         @(posedge clk); #1;
         start = 1'b0;
      end
      waited = 0;
      while (exp_q.size() != 0 && waited < 3 * LATENCY) begin
         @(posedge clk);
         waited++;
      end
      check(exp_q.size() == 0, req, "scan completed", exp_q.size(), 0);
      repeat (3) @(posedge clk);
      #1;
      check(done == 1'b0, "R5", "done low after scan", int'(done), 0);
      check(int'(diff) == e, "R5", "diff held", int'(diff), e);
      check(rd_addr == '0, "R7", "address rests at 0", int'(rd_addr), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R8", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
      repeat (4) @(posedge clk);
      #1;
      // R1: reset state
      check(done == 1'b0, "R1", "done in reset", int'(done), 0);
      check(diff == '0, "R1", "diff in reset", int'(diff), 0);
      check(rd_addr == '0, "R1", "rd_addr in reset", int'(rd_addr), 0);
      rst = 1'b0;
      repeat (2) @(posedge clk);

      // R2: random arrays
      for (int n = 0; n < 3; n++) begin
         for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
         scan("R2", 1'b0);
      end

      // R2: narrow random range
      for (int i = 0; i < DEPTH; i++) mem[i] = DW'(60 + ($urandom % 40));
      scan("R2", 1'b0);

      // R3: all equal
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h5A;
      scan("R3", 1'b0);
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'h00;
      scan("R3", 1'b0);

      // R4: extremes at the first and last address
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'd100;
      mem[0] = 8'd255;
      mem[DEPTH-1] = 8'd0;
      scan("R4", 1'b0);
      for (int i = 0; i < DEPTH; i++) mem[i] = 8'd100;
      mem[0] = 8'd3;
      mem[DEPTH-1] = 8'd200;
      scan("R4", 1'b0);

      // R7: start during a scan is ignored, then restart from address 0
      for (int i = 0; i < DEPTH; i++) mem[i] = DW'($urandom);
      scan("R7", 1'b1);
      for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i);
      scan("R7", 1'b0);

      finish_run();
   end

endmodule